// File: doc/BRIEF.md
# Word-Rate Enable Pulse Generator

A serializer hands the system a slow strobe at the parallel-word rate, asynchronous to the fast system clock. This block turns that strobe into a single-cycle enable inside the system clock domain. System-domain registers update only when the enable is high, so readout and serializer loading happen once per enable period, at a moment that is safe for the parallel word to change.

After reset the block waits a fixed start-up delay. It then looks for the first rising edge of the synchronized strobe and uses it to set the phase of a modulo-N counter. The mode select chooses N. From that point on the block runs free at that phase and does not look at the strobe again. It never re-aligns, even if the strobe drifts or stops. A locked flag reports that the phase has been fixed.

Top module: `cegen_top`

## Requirements
- R1: While reset is high, at each clock edge, `en_o` and `locked_o` are driven to 0. Reset is synchronous and active-high.
- R2: The divide ratio N is 12 when `mode_i` is 1, 4 or 6, and 6 for every other value. `mode_i` may change only while reset is high.
- R3: `strobe_a` passes through two synchronizing flops before it is used. Suppose it goes from 0 to 1 between two clock edges, and the lock conditions hold. Then `locked_o` and the first `en_o` pulse go high in the cycle that begins at the third rising clock edge after that change.
- R4: No lock is taken until TIMEOUT (default 16) rising clock edges have passed with reset low. Strobe edges that are detected before that are ignored.
- R5: Once `locked_o` is 1, it stays 1 until the next reset.
- R6: Once locked, `en_o` is high for exactly one cycle in every N cycles. The first pulse comes in the lock cycle. The phase never changes afterwards, whatever the strobe does, including shifting or stopping.
- R7: `en_o` is never high while `locked_o` is 0.
- R8: If `strobe_a` stays low, the block never locks and `en_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_a | input | 1 | Asynchronous word-rate strobe from the serializer |
| mode_i | input | 3 | Mode select; chooses divide-by-6 or divide-by-12 |
| en_o | output | 1 | Single-cycle enable pulse, one per word period |
| locked_o | output | 1 | High once the enable phase has been fixed |

## Verification
The assertions assume two things. First, `mode_i` is held steady whenever reset is low. Second, `strobe_a` changes away from the rising clock edge, so its value two edges back is a defined sample. The bench changes the mode only inside reset windows and moves the strobe only on falling clock edges. It uses strobe periods of 6 and 12 cycles, pulses one cycle wide, phase jumps after lock, and long idle stretches. None of these patterns break either assumption.

// File: rtl/cegen_pkg.sv
package cegen_pkg;

    localparam int MODE_W = 3;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_chain_t;

    typedef enum logic {
        LS_HUNT = 1'b0,
        LS_RUN  = 1'b1
    } lock_state_e;

    function automatic logic is_long_mode(input logic [MODE_W-1:0] m);
        return (m == 3'd1) || (m == 3'd4) || (m == 3'd6);
    endfunction

endpackage

// File: rtl/cegen_sync.sv
module cegen_sync
    import cegen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);

    sync_chain_t chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain.s1 <= async_i;
            chain.s2 <= chain.s1;
            chain.s3 <= chain.s2;
        end
    end

    assign rise_o = chain.s2 & ~chain.s3;

    // R3: a detected rise implies the strobe was high two edges earlier
    assert_rise_delay_R3: assert property (@(posedge clk) disable iff (rst)
        rise_o |-> $past(async_i, 2));

endmodule

// File: rtl/cegen_timer.sv
module cegen_timer #(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst,
    output logic done_o
);

    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign done_o = (cnt == LIMIT);

    assert_timer_saturates_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);

endmodule

// File: rtl/cegen_phase.sv
module cegen_phase
    import cegen_pkg::*;
#(
    parameter int DIV_LO = 6,
    parameter int DIV_HI = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              arm_i,
    input  logic              rise_i,
    output logic              en_o,
    output logic              locked_o
);

    localparam int PW = $clog2(DIV_HI);

    lock_state_e st;
    logic [PW-1:0] ph;
    logic [PW-1:0] last;

    assign last = is_long_mode(mode_i) ? PW'(DIV_HI - 1) : PW'(DIV_LO - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= LS_HUNT;
            ph <= '0;
        end else begin
            case (st)
                LS_HUNT: begin
                    if (arm_i && rise_i) begin
                        st <= LS_RUN;
                        ph <= '0;
                    end
                end
                LS_RUN: ph <= (ph == last) ? '0 : ph + 1'b1;
                default: st <= LS_HUNT;
            endcase
        end
    end

    assign locked_o = (st == LS_RUN);
    assign en_o     = locked_o && (ph == '0);

    // Independent gap counter for checking the pulse spacing
    logic [PW:0] chk_gap;
    logic        chk_seen;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_gap  <= '0;
            chk_seen <= 1'b0;
        end else if (en_o) begin
            chk_gap  <= '0;
            chk_seen <= 1'b1;
        end else begin
            chk_gap <= chk_gap + 1'b1;
        end
    end

    assert_en_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        (en_o && chk_seen) |-> (chk_gap == (PW+1)'(last)));
    assert_en_single_R6: assert property (@(posedge clk) disable iff (rst)
        en_o |=> !en_o);
    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        locked_o |=> locked_o);
    assert_lock_after_timeout_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(arm_i));
    assert_lock_on_edge_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(rise_i));

endmodule

// File: rtl/cegen_top.sv
module cegen_top
    import cegen_pkg::*;
#(
    parameter int TIMEOUT = 16,
    parameter int DIV_LO  = 6,
    parameter int DIV_HI  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_a,
    input  logic [MODE_W-1:0] mode_i,
    output logic              en_o,
    output logic              locked_o
);

    logic rise;
    logic armed;

    cegen_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (strobe_a),
        .rise_o  (rise)
    );

    cegen_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .done_o (armed)
    );

    cegen_phase #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .mode_i   (mode_i),
        .arm_i    (armed),
        .rise_i   (rise),
        .en_o     (en_o),
        .locked_o (locked_o)
    );

    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        $stable(mode_i));
    assert_no_en_unlocked_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> !$past(en_o));

endmodule

// File: tb/test_cegen_top.sv
module test_cegen_top;

    localparam int TIMEOUT = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe_a = 1'b0;
    logic [2:0] mode_i = 3'd0;
    logic       en_o;
    logic       locked_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cegen_top #(.TIMEOUT(TIMEOUT)) i_cegen_top (
        .clk      (clk),
        .rst      (rst),
        .strobe_a (strobe_a),
        .mode_i   (mode_i),
        .en_o     (en_o),
        .locked_o (locked_o)
    );

    // Behavioural reference model
    bit   hist[$];
    int   edges_seen = 0;
    bit   m_lock = 0;
    int   m_ph = 0;

    function automatic int ref_div(input logic [2:0] m);
        return (m == 3'd1 || m == 3'd4 || m == 3'd6) ? 12 : 6;
    endfunction

    initial begin
        hist = '{0, 0, 0};
    end

    always @(posedge clk) begin
        if (rst) begin
            hist = '{0, 0, 0};
            edges_seen = 0;
            m_lock = 0;
            m_ph = 0;
        end else begin
            bit seen_rise;
            seen_rise = hist[1] && !hist[2];
            if (!m_lock) begin
                if (edges_seen >= TIMEOUT && seen_rise) begin
                    m_lock = 1;
                    m_ph = 0;
                end
            end else begin
                m_ph = (m_ph + 1) % ref_div(mode_i);
            end
            hist.push_front(strobe_a);
            void'(hist.pop_back());
            edges_seen++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison (R3 R4 R5 R6 R7)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit exp_en;
            exp_en = m_lock && (m_ph == 0);
            check(locked_o == m_lock, m_lock ? "R3/R5 locked" : "R4 locked", locked_o, m_lock);
            check(en_o == exp_en, m_lock ? "R6 en" : "R7 en", en_o, exp_en);
        end
    end

    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        rst = 1'b1;
        strobe_a = 1'b0;
        repeat (2) @(negedge clk);
        mode_i = m;
        repeat (2) @(negedge clk);
        check(en_o == 1'b0, "R1 en in reset", en_o, 0);
        check(locked_o == 1'b0, "R1 locked in reset", locked_o, 0);
        rst = 1'b0;
    endtask

    task automatic strobe_run(input int periods, input int div, input int hi);
        for (int p = 0; p < periods; p++) begin
            for (int c = 0; c < div; c++) begin
                @(negedge clk);
                strobe_a = (c < hi);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            strobe_a = 1'b0;
        end
    endtask

    initial begin
        // Scenario A: divide-by-6, edges during timeout ignored (R4), phase shift after lock (R6)
        do_reset(3'd0);
        strobe_run(20, 6, 3);
        check(locked_o == 1'b1, "R2 mode0 lock", locked_o, 1);
        idle(2);
        strobe_run(10, 6, 3);
        idle(30);
        check(locked_o == 1'b1, "R5 lock held", locked_o, 1);

        // Scenario B: divide-by-12 in mode 4 (R2)
        do_reset(3'd4);
        strobe_run(10, 12, 6);

        // Scenario C: strobe stuck low never locks (R8), then mode 7 is divide-by-6
        do_reset(3'd7);
        idle(120);
        check(locked_o == 1'b0, "R8 no lock", locked_o, 0);
        check(en_o == 1'b0, "R8 no enable", en_o, 0);
        strobe_run(8, 6, 2);

        // Scenario D: mode 1, single-cycle strobe with offset, then strobe stops (R3 R6)
        do_reset(3'd1);
        idle(21);
        strobe_run(8, 12, 1);
        idle(40);

        // Scenario E: mode 6, late first edge
        do_reset(3'd6);
        idle(50);
        strobe_run(6, 12, 4);

        @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule